// File: doc/BRIEF.md
# Packed masked multiply-high accumulate unit

This unit is a vector datapath that splits a 512-bit register into eight 64-bit lanes. In each lane that is enabled, it takes the low 52 bits of the two source lanes, multiplies them as unsigned numbers into a 104-bit product, and adds the upper 52 bits of that product to the 64-bit accumulator lane. The sum wraps modulo 2^64. A typical user is wide-integer modular arithmetic, where operands are held in radix-2^52 limbs and the high and low halves of each partial product are accumulated separately.

A per-lane mask decides which lanes are computed, and the mask can be switched off. An inactive lane is either cleared or keeps its old accumulator value, depending on a mode bit. A broadcast flag feeds the lowest 52-bit element of the second source to every lane. A vector-length select limits the operation to 2, 4 or 8 lanes, and every lane above that limit is cleared. The unit is a two-stage pipeline that accepts one operation per clock.

Top module: `pmhacc_unit`

## Requirements
- R1: Each computed lane takes bits [51:0] of `src_a` and bits [51:0] of the second operand, zero-extends both, forms the 104-bit unsigned product, and outputs the `acc_in` lane plus product bits [103:52] zero-extended to 64 bits.
- R2: The 64-bit lane sum wraps modulo 2^64. There is no carry-out, saturation or flag.
- R3: A lane is computed when `mask_en` is 0, or when `mask_en` is 1 and bit j of `lane_mask` is 1 (bit j controls lane j, which occupies bits [64j+63:64j]).
- R4: When `zero_mode` is 1, an inactive lane outputs 0. When `zero_mode` is 0, it outputs its `acc_in` lane unchanged.
- R5: When `bcast` is 1, `src_b[51:0]` is the second operand in every lane. When `bcast` is 0, lane j uses its own `src_b` lane.
- R6: `vlen` selects the lanes in range: 2'b00 gives lanes 0-1, 2'b01 gives lanes 0-3, and 2'b10 and 2'b11 give lanes 0-7. Every lane out of range outputs 0, whatever the mask and mode.
- R7: Bits [63:52] of every `src_a` and `src_b` lane have no effect on `result`.
- R8: When `in_valid` is sampled high at a rising edge, `out_valid` is high and `result` holds that operation after the second rising edge that follows. A new operation may be presented on every cycle.
- R9: A synchronous active-high `rst` clears `out_valid` and `result` to 0 and discards any operations in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| src_a | input | 512 | First multiplicand vector |
| src_b | input | 512 | Second multiplicand vector |
| acc_in | input | 512 | Current accumulator vector |
| lane_mask | input | 8 | Per-lane enable, bit j for lane j |
| mask_en | input | 1 | 1 = apply `lane_mask`, 0 = compute every lane |
| zero_mode | input | 1 | 1 = inactive lanes cleared, 0 = inactive lanes keep `acc_in` |
| bcast | input | 1 | 1 = use `src_b[51:0]` for all lanes |
| vlen | input | 2 | 00 = 2 lanes, 01 = 4 lanes, 10/11 = 8 lanes |
| out_valid | output | 1 | `result` holds a finished operation |
| result | output | 512 | New accumulator vector |

## Verification
The bench sweeps every combination of vector length, mask enable, zeroing mode and broadcast against the mask patterns 0x00, 0xFF, 0xA5 and 0x5A plus a random mask. It compares each result with a 128-bit arithmetic model. A design that let lanes above the selected length through, or that swapped zeroing and merging, would show a wrong lane in one of these sweeps. A design that read a per-lane second operand while broadcast is set would show a wrong lane as well. Every source lane carries random data in bits [63:52], so a multiplier wider than 52 bits gives a different product. An all-ones 52-bit pair added to an accumulator of 2^64-1 checks that the sum wraps and that no carry leaks into the next lane. Back-to-back issue with idle gaps, plus a reset while operations are in flight, expose a wrong latency or stale valid bits.

// File: rtl/pmhacc_unit.sv
module pmhacc_unit #(
  parameter int LANES = 8,
  parameter int LW    = 64,
  parameter int OPW   = 52
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*LW-1:0] src_a,
  input  logic [LANES*LW-1:0] src_b,
  input  logic [LANES*LW-1:0] acc_in,
  input  logic [LANES-1:0]    lane_mask,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic                bcast,
  input  logic [1:0]          vlen,
  output logic                out_valid,
  output logic [LANES*LW-1:0] result
);
  localparam int PW = 2 * OPW;
  localparam int VW = LANES * LW;

  logic             s1_valid;
  logic             s1_zero;
  logic [LANES-1:0] s1_act;
  logic [LANES-1:0] s1_rng;
  logic [OPW-1:0]   s1_hi  [LANES];
  logic [LW-1:0]    s1_acc [LANES];

  logic [LANES-1:0] act_w;
  logic [LANES-1:0] rng_w;
  logic [VW-1:0]    next_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_zero   <= 1'b0;
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      s1_valid  <= in_valid;
      s1_zero   <= zero_mode;
      out_valid <= s1_valid;
      if (s1_valid) result <= next_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_act <= '0;
      s1_rng <= '0;
    end else if (in_valid) begin
      s1_act <= act_w;
      s1_rng <= rng_w;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [OPW-1:0] a_op;
    logic [OPW-1:0] b_op;
    logic [PW-1:0]  prod;

    assign a_op  = src_a[j*LW +: OPW];
    assign b_op  = bcast ? src_b[OPW-1:0] : src_b[j*LW +: OPW];
    assign prod  = {{OPW{1'b0}}, a_op} * {{OPW{1'b0}}, b_op};
    assign act_w[j] = !mask_en || lane_mask[j];
    assign rng_w[j] = (vlen == 2'b00) ? (j < LANES / 4) :
                      (vlen == 2'b01) ? (j < LANES / 2) : 1'b1;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_hi[j]  <= '0;
        s1_acc[j] <= '0;
      end else if (in_valid) begin
        s1_hi[j]  <= prod[PW-1:OPW];
        s1_acc[j] <= acc_in[j*LW +: LW];
      end
    end

    assign next_w[j*LW +: LW] =
      !s1_rng[j] ? '0 :
      s1_act[j]  ? s1_acc[j] + {{(LW-OPW){1'b0}}, s1_hi[j]} :
      s1_zero    ? '0 : s1_acc[j];
  end
endmodule

module pmhacc_chk #(
  parameter int LANES = 8,
  parameter int LW    = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [LANES*LW-1:0] acc_in,
  input logic [LANES-1:0]    lane_mask,
  input logic                mask_en,
  input logic                zero_mode,
  input logic [1:0]          vlen,
  input logic                out_valid,
  input logic [LANES*LW-1:0] result
);
  // R8
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  // R6
  short_len_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(vlen, 2) == 2'b00) |-> result[LANES*LW-1:2*LW] == '0);

  // R4
  merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mask_en, 2) && !$past(zero_mode, 2) && !$past(lane_mask[0], 2))
      |-> result[LW-1:0] == $past(acc_in[LW-1:0], 2));

  // R4
  zero_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mask_en, 2) && $past(zero_mode, 2) && !$past(lane_mask[0], 2))
      |-> result[LW-1:0] == '0);
endmodule

bind pmhacc_unit pmhacc_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
  .lane_mask(lane_mask), .mask_en(mask_en), .zero_mode(zero_mode),
  .vlen(vlen), .out_valid(out_valid), .result(result)
);

// File: tb/tb_pmhacc_unit.sv
module tb_pmhacc_unit;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [511:0] src_a = '0, src_b = '0, acc_in = '0;
  logic [7:0]   lane_mask = '0;
  logic         mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0;
  logic [1:0]   vlen = 2'b00;
  logic         out_valid;
  logic [511:0] result;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic         e1_v = 0, e2_v = 0;
  logic [511:0] e1_r = '0, e2_r = '0;
  string        e1_t = "", e2_t = "";

  pmhacc_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .lane_mask(lane_mask), .mask_en(mask_en),
    .zero_mode(zero_mode), .bcast(bcast), .vlen(vlen),
    .out_valid(out_valid), .result(result)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [511:0] model(logic [511:0] a, logic [511:0] b,
      logic [511:0] c, logic [7:0] m, logic me, logic zm, logic bc, logic [1:0] vl);
    logic [511:0] r = '0;
    int nl = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
    for (int j = 0; j < 8; j++) begin
      logic [127:0] x, y, p;
      logic [63:0]  old = c[j*64 +: 64];
      x = {76'b0, a[j*64 +: 52]};
      y = bc ? {76'b0, b[51:0]} : {76'b0, b[j*64 +: 52]};
      p = x * y;
      if (j >= nl)             r[j*64 +: 64] = 64'h0;
      else if (!me || m[j])    r[j*64 +: 64] = old + {12'b0, p[103:52]};
      else if (zm)             r[j*64 +: 64] = 64'h0;
      else                     r[j*64 +: 64] = old;
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_out();
    n_chk++;
    if (e2_v) begin
      if (out_valid !== 1'b1 || result !== e2_r) begin
        n_bad++;
        $display("FAIL %s: valid=%b result=%h expected valid=1 result=%h",
                 e2_t, out_valid, result, e2_r);
      end
    end else if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: out_valid=%b expected 0", out_valid);
    end
  endtask

  task automatic step(logic v, logic [511:0] a, logic [511:0] b, logic [511:0] c,
      logic [7:0] m, logic me, logic zm, logic bc, logic [1:0] vl, string tag);
    @(negedge clk);
    check_out();
    e2_v = e1_v; e2_r = e1_r; e2_t = e1_t;
    e1_v = v;    e1_r = model(a, b, c, m, me, zm, bc, vl); e1_t = tag;
    in_valid = v; src_a = a; src_b = b; acc_in = c; lane_mask = m;
    mask_en = me; zero_mode = zm; bcast = bc; vlen = vl;
  endtask

  task automatic idle();
    step(1'b0, '0, '0, '0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b10, "R8");
  endtask

  initial begin
    #(CLK_NS*200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [5];
    logic [511:0] ones, big;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A; pats[4] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    n_chk++;
    if (out_valid !== 1'b0 || result !== '0) begin
      n_bad++;
      $display("FAIL R9: valid=%b result=%h expected 0/0", out_valid, result);
    end
    rst = 1'b0;

    // R1,R3,R4,R5,R6,R7: full mode sweep, back-to-back issue (R8)
    for (int vl = 0; vl < 4; vl++)
      for (int me = 0; me < 2; me++)
        for (int zm = 0; zm < 2; zm++)
          for (int bc = 0; bc < 2; bc++)
            for (int pi = 0; pi < 5; pi++) begin
              logic [7:0] m = (pi == 4) ? 8'($urandom) : pats[pi];
              step(1'b1, rnd512(), rnd512(), rnd512(), m, me[0], zm[0], bc[0],
                   vl[1:0], "R1,R3,R4,R5,R6,R7");
              if (pi == 2) idle();
            end

    // R2: all-ones operands with accumulator near 2^64 force wrap
    for (int k = 0; k < 8; k++) begin
      ones[k*64 +: 64] = {12'hFFF, 52'hF_FFFF_FFFF_FFFF};
      big[k*64 +: 64]  = 64'hFFFF_FFFF_FFFF_FFFF - 64'(k);
    end
    step(1'b1, ones, ones, big, 8'hFF, 1'b1, 1'b0, 1'b0, 2'b10, "R2");
    step(1'b1, ones, ones, big, 8'h00, 1'b0, 1'b1, 1'b1, 2'b11, "R2,R5");

    // R7: only bits 63:52 differ between two otherwise equal operations
    begin
      logic [511:0] a0 = rnd512(), b0 = rnd512(), c0 = rnd512(), a1, b1;
      a1 = a0; b1 = b0;
      for (int k = 0; k < 8; k++) begin
        a1[k*64+52 +: 12] = ~a0[k*64+52 +: 12];
        b1[k*64+52 +: 12] = ~b0[k*64+52 +: 12];
      end
      step(1'b1, a0, b0, c0, 8'hFF, 1'b1, 1'b0, 1'b0, 2'b10, "R7");
      step(1'b1, a1, b1, c0, 8'hFF, 1'b1, 1'b0, 1'b0, 2'b10, "R7");
    end

    // R9: reset with operations in flight
    step(1'b1, rnd512(), rnd512(), rnd512(), 8'hFF, 1'b0, 1'b0, 1'b0, 2'b10, "R9");
    @(negedge clk);
    check_out();
    e2_v = e1_v; e2_r = e1_r; e2_t = e1_t;
    e1_v = 0;
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || result !== '0) begin
      n_bad++;
      $display("FAIL R9: valid=%b result=%h expected 0/0", out_valid, result);
    end
    rst = 1'b0;
    e1_v = 0; e2_v = 0;
    idle(); idle(); idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule